// File: doc/BRIEF.md
# SPI FIFO DMA Request Controller

This block holds the transmit and receive byte queues of a serial peripheral port. It decides when to ask a DMA engine for more work by comparing each queue's fill level against a programmable threshold. The system bus pushes transmit bytes and pops receive bytes. The serial shifter pops transmit bytes and pushes receive bytes. The two thresholds point in opposite directions. The receive side requests service once enough bytes have gathered. The transmit side requests service while the queue is running low.

Errors on the bus side always raise sticky flags. Errors on the shifter side raise a flag only when the port runs as a slave, because a slave cannot hold back the external clock. As a master, the block raises a stall line instead, and the shifter must freeze its clock until the queue can move. A single control word sets the thresholds, the transmit DMA enable and the transmit queue enable. The same word carries a self-clearing bit that flushes the transmit queue. A separate mask write clears the sticky error flags.

Top module: `spi_fifo_dma_ctrl`

## Requirements
- R1: While reset is held, both counts, all flags and both DMA requests are 0, and `cfgRdData` reads 13'h200. In that value the receive level (bits 4:0) is 0, the transmit level (bits 9:5) is 16, and the DMA enable (bit 10), queue enable (bit 11) and clear (bit 12) are all 0.
- R2: Each queue is 32 bytes deep and first-in first-out. `shTxData` and `busRxData` show the oldest byte. The count moves by one per accepted push or pop. A push and a pop accepted in the same cycle leave the count unchanged.
- R3: `rxThresh` and `rxDmaReq` are registered. Each is 1 one cycle after a cycle in which `rxCount` is greater than or equal to the receive level. A level of 0 therefore requests at all times.
- R4: `txThresh` is 1 one cycle after a cycle in which `txCount` is strictly below the transmit level. `txDmaReq` follows the same rule but also needs DMA enable bit 10. Writing that bit to 0 drops the request on the next cycle.
- R5: While queue enable bit 11 is 0, bus pushes to the transmit queue are ignored: nothing is stored and no overrun is flagged.
- R6: A control write with bit 12 set empties the transmit queue and clears `txOvr` and `txUnd`. It also forces `txThresh` and `txDmaReq` to 0 for the next cycle. It overrides any transmit push, pop or flag event in the same cycle. Bit 12 always reads 0, and writing it as 0 leaves the queue untouched.
- R7: A bus push while `txCount` is 32 sets `txOvr` and drops the byte, even if a shifter pop happens in the same cycle. A bus pop while `rxCount` is 0 sets `rxUnd`.
- R8: With `slaveMode` = 1, a shifter push into a full receive queue sets `rxOvr` and drops the byte. A shifter pop from an empty transmit queue sets `txUnd`.
- R9: With `slaveMode` = 0, shifter accesses never set `rxOvr` or `txUnd`. `sclkStall` is 1 exactly when `slaveMode` = 0 and either `txCount` is 0 or `rxCount` is 32.
- R10: The four error flags hold until cleared. A cycle with `flagClrEn` = 1 clears each flag whose mask bit is 1 (bit 0 `txOvr`, bit 1 `txUnd`, bit 2 `rxOvr`, bit 3 `rxUnd`). A setting event in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cfgWrEn | input | 1 | Control word write strobe |
| cfgWrData | input | 13 | Control word: rx level, tx level, DMA enable, queue enable, clear |
| cfgRdData | output | 13 | Stored control fields (clear bit reads 0) |
| flagClrEn | input | 1 | Error flag clear strobe |
| flagClrMask | input | 4 | Flags to clear: txOvr, txUnd, rxOvr, rxUnd |
| slaveMode | input | 1 | 1 = slave, 0 = master |
| busTxPush | input | 1 | Bus writes a transmit byte |
| busTxData | input | 8 | Transmit byte from the bus |
| busRxPop | input | 1 | Bus takes a receive byte |
| busRxData | output | 8 | Oldest receive byte |
| shTxPop | input | 1 | Shifter takes a transmit byte |
| shTxData | output | 8 | Oldest transmit byte |
| shRxPush | input | 1 | Shifter stores a receive byte |
| shRxData | input | 8 | Receive byte from the shifter |
| txCount | output | 6 | Bytes held in the transmit queue |
| rxCount | output | 6 | Bytes held in the receive queue |
| txThresh | output | 1 | Transmit level below threshold |
| rxThresh | output | 1 | Receive level at or above threshold |
| txDmaReq | output | 1 | Transmit DMA request |
| rxDmaReq | output | 1 | Receive DMA request |
| txOvr | output | 1 | Sticky transmit overrun |
| txUnd | output | 1 | Sticky transmit underrun |
| rxOvr | output | 1 | Sticky receive overrun |
| rxUnd | output | 1 | Sticky receive underrun |
| sclkStall | output | 1 | Master-mode request to freeze the serial clock |

## Verification
Two cases of same-cycle conflict are covered.

The first is a sticky-flag clear that arrives in the same cycle as a new setting event. The bench forces this by pushing into a full transmit queue while the overrun mask bit is written, and then checks that `txOvr` stays set.

The second is a transmit flush that lands together with a bus push. The bench checks that the count ends at zero and that the threshold and request outputs drop for exactly one cycle.

A random phase mixes pushes, pops, mask clears, flushes and mode changes from cycle to cycle. A queue-based reference model is compared against every output on every clock.

// File: rtl/spi_fifo_pkg.sv
package spi_fifo_pkg;
  localparam int CFG_W      = 13;
  localparam int LVL_W      = 5;
  localparam int RXLVL_LSB  = 0;
  localparam int TXLVL_LSB  = 5;
  localparam int TXDMA_BIT  = 10;
  localparam int TXEN_BIT   = 11;
  localparam int TXCLR_BIT  = 12;
  localparam int TXLVL_RST  = 16;
  localparam int FLAG_W     = 4;
  localparam int CLR_TXOVR  = 0;
  localparam int CLR_TXUND  = 1;
  localparam int CLR_RXOVR  = 2;
  localparam int CLR_RXUND  = 3;

  // strobes from control to datapath
  typedef struct packed {
    logic txPush;
    logic txPop;
    logic txFlush;
    logic rxPush;
    logic rxPop;
  } fifoStrobe_t;
endpackage

// File: rtl/spi_byte_fifo.sv
module spi_byte_fifo #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 32,
  localparam int AW    = $clog2(DEPTH),
  localparam int CW    = AW + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              push,
  input  logic              pop,
  input  logic              flush,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic [CW-1:0]     count
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0] wrPtr, rdPtr;

  function automatic logic [AW-1:0] nextPtr(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wrPtr] <= wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else if (flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (push) wrPtr <= nextPtr(wrPtr);
      if (pop)  rdPtr <= nextPtr(rdPtr);
      if (push && !pop)      count <= count + 1'b1;
      else if (pop && !push) count <= count - 1'b1;
    end
  end

  assign rdData = mem[rdPtr];
endmodule

// File: rtl/spi_fifo_dp.sv
module spi_fifo_dp
  import spi_fifo_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 32,
  localparam int CW    = $clog2(DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  fifoStrobe_t       strobe,
  input  logic [DATA_W-1:0] busTxData,
  input  logic [DATA_W-1:0] shRxData,
  output logic [DATA_W-1:0] shTxData,
  output logic [DATA_W-1:0] busRxData,
  output logic [CW-1:0]     txCount,
  output logic [CW-1:0]     rxCount
);
  spi_byte_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) uTxFifo (
    .clk(clk), .rstN(rstN),
    .push(strobe.txPush), .pop(strobe.txPop), .flush(strobe.txFlush),
    .wrData(busTxData), .rdData(shTxData), .count(txCount)
  );

  spi_byte_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) uRxFifo (
    .clk(clk), .rstN(rstN),
    .push(strobe.rxPush), .pop(strobe.rxPop), .flush(1'b0),
    .wrData(shRxData), .rdData(busRxData), .count(rxCount)
  );
endmodule

// File: rtl/spi_fifo_ctrl.sv
module spi_fifo_ctrl
  import spi_fifo_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int CW   = $clog2(DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [CFG_W-1:0]  cfgWrData,
  output logic [CFG_W-1:0]  cfgRdData,
  input  logic              flagClrEn,
  input  logic [FLAG_W-1:0] flagClrMask,
  input  logic              slaveMode,
  input  logic              busTxPush,
  input  logic              busRxPop,
  input  logic              shTxPop,
  input  logic              shRxPush,
  input  logic [CW-1:0]     txCount,
  input  logic [CW-1:0]     rxCount,
  output fifoStrobe_t       strobe,
  output logic              txThresh,
  output logic              rxThresh,
  output logic              txDmaReq,
  output logic              rxDmaReq,
  output logic              txOvr,
  output logic              txUnd,
  output logic              rxOvr,
  output logic              rxUnd,
  output logic              sclkStall
);
  logic [LVL_W-1:0] rxLevel, txLevel;
  logic txDmaEn, txFifoEn;
  logic txFull, txEmpty, rxFull, rxEmpty, flushNow;
  logic evTxOvr, evTxUnd, evRxOvr, evRxUnd;
  logic [FLAG_W-1:0] clrHit;

  assign txFull   = (txCount == CW'(DEPTH));
  assign txEmpty  = (txCount == '0);
  assign rxFull   = (rxCount == CW'(DEPTH));
  assign rxEmpty  = (rxCount == '0);
  assign flushNow = cfgWrEn && cfgWrData[TXCLR_BIT];
  assign clrHit   = flagClrEn ? flagClrMask : '0;

  // strobes issued to the datapath; never push full or pop empty
  always_comb begin
    strobe.txFlush = flushNow;
    strobe.txPush  = busTxPush && txFifoEn && !txFull && !flushNow;
    strobe.txPop   = shTxPop && !txEmpty && !flushNow;
    strobe.rxPush  = shRxPush && !rxFull;
    strobe.rxPop   = busRxPop && !rxEmpty;
  end

  assign evTxOvr = busTxPush && txFifoEn && txFull;
  assign evTxUnd = shTxPop && txEmpty && slaveMode;
  assign evRxOvr = shRxPush && rxFull && slaveMode;
  assign evRxUnd = busRxPop && rxEmpty;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxLevel  <= '0;
      txLevel  <= LVL_W'(TXLVL_RST);
      txDmaEn  <= 1'b0;
      txFifoEn <= 1'b0;
    end else if (cfgWrEn) begin
      rxLevel  <= cfgWrData[RXLVL_LSB +: LVL_W];
      txLevel  <= cfgWrData[TXLVL_LSB +: LVL_W];
      txDmaEn  <= cfgWrData[TXDMA_BIT];
      txFifoEn <= cfgWrData[TXEN_BIT];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txThresh <= 1'b0;
      txDmaReq <= 1'b0;
      rxThresh <= 1'b0;
      rxDmaReq <= 1'b0;
      txOvr    <= 1'b0;
      txUnd    <= 1'b0;
      rxOvr    <= 1'b0;
      rxUnd    <= 1'b0;
    end else begin
      rxThresh <= rxCount >= CW'(rxLevel);
      rxDmaReq <= rxCount >= CW'(rxLevel);
      rxOvr    <= evRxOvr || (rxOvr && !clrHit[CLR_RXOVR]);
      rxUnd    <= evRxUnd || (rxUnd && !clrHit[CLR_RXUND]);
      if (flushNow) begin
        txThresh <= 1'b0;
        txDmaReq <= 1'b0;
        txOvr    <= 1'b0;
        txUnd    <= 1'b0;
      end else begin
        txThresh <= txCount < CW'(txLevel);
        txDmaReq <= txDmaEn && (txCount < CW'(txLevel));
        txOvr    <= evTxOvr || (txOvr && !clrHit[CLR_TXOVR]);
        txUnd    <= evTxUnd || (txUnd && !clrHit[CLR_TXUND]);
      end
    end
  end

  assign sclkStall = !slaveMode && (txEmpty || rxFull);
  assign cfgRdData = {1'b0, txFifoEn, txDmaEn, txLevel, rxLevel};
endmodule

// File: rtl/spi_fifo_dma_ctrl.sv
module spi_fifo_dma_ctrl
  import spi_fifo_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 32,
  localparam int CW    = $clog2(DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [CFG_W-1:0]  cfgWrData,
  output logic [CFG_W-1:0]  cfgRdData,
  input  logic              flagClrEn,
  input  logic [FLAG_W-1:0] flagClrMask,
  input  logic              slaveMode,
  input  logic              busTxPush,
  input  logic [DATA_W-1:0] busTxData,
  input  logic              busRxPop,
  output logic [DATA_W-1:0] busRxData,
  input  logic              shTxPop,
  output logic [DATA_W-1:0] shTxData,
  input  logic              shRxPush,
  input  logic [DATA_W-1:0] shRxData,
  output logic [CW-1:0]     txCount,
  output logic [CW-1:0]     rxCount,
  output logic              txThresh,
  output logic              rxThresh,
  output logic              txDmaReq,
  output logic              rxDmaReq,
  output logic              txOvr,
  output logic              txUnd,
  output logic              rxOvr,
  output logic              rxUnd,
  output logic              sclkStall
);
  fifoStrobe_t strobe;

  spi_fifo_ctrl #(.DEPTH(DEPTH)) uCtrl (
    .clk(clk), .rstN(rstN),
    .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData), .cfgRdData(cfgRdData),
    .flagClrEn(flagClrEn), .flagClrMask(flagClrMask), .slaveMode(slaveMode),
    .busTxPush(busTxPush), .busRxPop(busRxPop),
    .shTxPop(shTxPop), .shRxPush(shRxPush),
    .txCount(txCount), .rxCount(rxCount), .strobe(strobe),
    .txThresh(txThresh), .rxThresh(rxThresh),
    .txDmaReq(txDmaReq), .rxDmaReq(rxDmaReq),
    .txOvr(txOvr), .txUnd(txUnd), .rxOvr(rxOvr), .rxUnd(rxUnd),
    .sclkStall(sclkStall)
  );

  spi_fifo_dp #(.DATA_W(DATA_W), .DEPTH(DEPTH)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .busTxData(busTxData), .shRxData(shRxData),
    .shTxData(shTxData), .busRxData(busRxData),
    .txCount(txCount), .rxCount(rxCount)
  );
endmodule

// File: rtl/spi_fifo_dma_chk.sv
module spi_fifo_dma_chk
  import spi_fifo_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int CW   = $clog2(DEPTH) + 1
) (
  input logic              clk,
  input logic              rstN,
  input logic              cfgWrEn,
  input logic [CFG_W-1:0]  cfgWrData,
  input logic [CFG_W-1:0]  cfgRdData,
  input logic              flagClrEn,
  input logic [FLAG_W-1:0] flagClrMask,
  input logic              slaveMode,
  input logic              busTxPush,
  input logic [CW-1:0]     txCount,
  input logic [CW-1:0]     rxCount,
  input logic              txDmaReq,
  input logic              rxDmaReq,
  input logic              txOvr,
  input logic              txUnd,
  input logic              rxOvr
);
  logic flushNow;
  assign flushNow = cfgWrEn && cfgWrData[TXCLR_BIT];

  assert_count_bound_R2: assert property (@(posedge clk) disable iff (!rstN)
    (txCount <= CW'(DEPTH)) && (rxCount <= CW'(DEPTH)));

  assert_rx_req_level_R3: assert property (@(posedge clk) disable iff (!rstN)
    (rxCount >= CW'(cfgRdData[RXLVL_LSB +: LVL_W])) |=> rxDmaReq);

  assert_tx_req_gated_R4: assert property (@(posedge clk) disable iff (!rstN)
    txDmaReq |-> $past(cfgRdData[TXDMA_BIT]));

  assert_flush_empties_R6: assert property (@(posedge clk) disable iff (!rstN)
    flushNow |=> (txCount == '0) && !txOvr && !txUnd && !txDmaReq);

  assert_ovr_on_full_R7: assert property (@(posedge clk) disable iff (!rstN)
    (busTxPush && cfgRdData[TXEN_BIT] && txCount == CW'(DEPTH) && !flushNow) |=> txOvr);

  assert_master_no_rxovr_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!slaveMode && !rxOvr) |=> !rxOvr);

  assert_master_no_txund_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!slaveMode && !txUnd) |=> !txUnd);

  assert_ovr_sticky_R10: assert property (@(posedge clk) disable iff (!rstN)
    (txOvr && !(flagClrEn && flagClrMask[CLR_TXOVR]) && !flushNow) |=> txOvr);
endmodule

bind spi_fifo_dma_ctrl spi_fifo_dma_chk #(.DEPTH(DEPTH)) uChk (
  .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData),
  .cfgRdData(cfgRdData), .flagClrEn(flagClrEn), .flagClrMask(flagClrMask),
  .slaveMode(slaveMode), .busTxPush(busTxPush),
  .txCount(txCount), .rxCount(rxCount),
  .txDmaReq(txDmaReq), .rxDmaReq(rxDmaReq),
  .txOvr(txOvr), .txUnd(txUnd), .rxOvr(rxOvr)
);

// File: tb/spi_fifo_dma_ctrl_test.sv
`timescale 1ns/100ps
module spi_fifo_dma_ctrl_test;
  localparam int DEPTH = 32;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgWrEn = 0, flagClrEn = 0, slaveMode = 1;
  logic [12:0] cfgWrData = '0;
  logic [12:0] cfgRdData;
  logic [3:0] flagClrMask = '0;
  logic busTxPush = 0, busRxPop = 0, shTxPop = 0, shRxPush = 0;
  logic [7:0] busTxData = '0, shRxData = '0, busRxData, shTxData;
  logic [5:0] txCount, rxCount;
  logic txThresh, rxThresh, txDmaReq, rxDmaReq, txOvr, txUnd, rxOvr, rxUnd, sclkStall;

  always #2.5 clk = ~clk;

  spi_fifo_dma_ctrl uut (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData),
    .cfgRdData(cfgRdData), .flagClrEn(flagClrEn), .flagClrMask(flagClrMask),
    .slaveMode(slaveMode), .busTxPush(busTxPush), .busTxData(busTxData),
    .busRxPop(busRxPop), .busRxData(busRxData), .shTxPop(shTxPop),
    .shTxData(shTxData), .shRxPush(shRxPush), .shRxData(shRxData),
    .txCount(txCount), .rxCount(rxCount), .txThresh(txThresh),
    .rxThresh(rxThresh), .txDmaReq(txDmaReq), .rxDmaReq(rxDmaReq),
    .txOvr(txOvr), .txUnd(txUnd), .rxOvr(rxOvr), .rxUnd(rxUnd),
    .sclkStall(sclkStall)
  );

  int checks = 0, fails = 0;
  bit live = 0;

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  // reference model
  byte unsigned txq[$], rxq[$];
  int  mRxLvl, mTxLvl, tc, rc;
  bit  mDmaEn, mFifoEn, mTxTh, mTxReq, mRxTh, mRxReq;
  bit  mTxOvr, mTxUnd, mRxOvr, mRxUnd, flush, nTxTh, nRxTh, eA, eB;

  always @(posedge clk) begin
    if (!rstN) begin
      txq.delete(); rxq.delete();
      mRxLvl = 0; mTxLvl = 16; mDmaEn = 0; mFifoEn = 0;
      mTxTh = 0; mTxReq = 0; mRxTh = 0; mRxReq = 0;
      mTxOvr = 0; mTxUnd = 0; mRxOvr = 0; mRxUnd = 0;
    end else begin
      flush = cfgWrEn && cfgWrData[12];
      tc = txq.size(); rc = rxq.size();
      nTxTh = !flush && (tc < mTxLvl);
      nRxTh = rc >= mRxLvl;
      if (flush) begin
        txq.delete(); mTxOvr = 0; mTxUnd = 0;
      end else begin
        eA = busTxPush && mFifoEn && tc == DEPTH;
        eB = shTxPop && tc == 0 && slaveMode;
        if (shTxPop && tc > 0) void'(txq.pop_front());
        if (busTxPush && mFifoEn && tc < DEPTH) txq.push_back(busTxData);
        mTxOvr = eA || (mTxOvr && !(flagClrEn && flagClrMask[0]));
        mTxUnd = eB || (mTxUnd && !(flagClrEn && flagClrMask[1]));
      end
      eA = shRxPush && rc == DEPTH && slaveMode;
      eB = busRxPop && rc == 0;
      if (busRxPop && rc > 0) void'(rxq.pop_front());
      if (shRxPush && rc < DEPTH) rxq.push_back(shRxData);
      mRxOvr = eA || (mRxOvr && !(flagClrEn && flagClrMask[2]));
      mRxUnd = eB || (mRxUnd && !(flagClrEn && flagClrMask[3]));
      mTxTh = nTxTh; mTxReq = nTxTh && mDmaEn;
      mRxTh = nRxTh; mRxReq = nRxTh;
      if (cfgWrEn) begin
        mRxLvl = cfgWrData[4:0]; mTxLvl = cfgWrData[9:5];
        mDmaEn = cfgWrData[10]; mFifoEn = cfgWrData[11];
      end
    end
  end

  // cycle-by-cycle comparison
  always @(negedge clk) begin
    if (rstN && live) begin
      check("R2 txCount", int'(txCount), txq.size());
      check("R2 rxCount", int'(rxCount), rxq.size());
      if (txq.size() > 0) check("R2 shTxData", int'(shTxData), int'(txq[0]));
      if (rxq.size() > 0) check("R2 busRxData", int'(busRxData), int'(rxq[0]));
      check("R3 rxThresh", int'(rxThresh), int'(mRxTh));
      check("R3 rxDmaReq", int'(rxDmaReq), int'(mRxReq));
      check("R4 txThresh", int'(txThresh), int'(mTxTh));
      check("R4 txDmaReq", int'(txDmaReq), int'(mTxReq));
      check("R7 txOvr", int'(txOvr), int'(mTxOvr));
      check("R7 rxUnd", int'(rxUnd), int'(mRxUnd));
      check("R8 rxOvr", int'(rxOvr), int'(mRxOvr));
      check("R8 txUnd", int'(txUnd), int'(mTxUnd));
      check("R9 sclkStall", int'(sclkStall),
            int'(!slaveMode && (txq.size() == 0 || rxq.size() == DEPTH)));
      check("R1 cfgRdData", int'(cfgRdData),
            (mFifoEn << 11) | (mDmaEn << 10) | (mTxLvl << 5) | mRxLvl);
    end
  end

  task automatic tick();
    @(posedge clk); #1;
    cfgWrEn = 0; flagClrEn = 0; flagClrMask = '0;
    busTxPush = 0; busRxPop = 0; shTxPop = 0; shRxPush = 0;
  endtask

  task automatic cfg(int rxl, int txl, bit dma, bit en, bit clr);
    cfgWrEn = 1;
    cfgWrData = {clr, en, dma, 5'(txl), 5'(rxl)};
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=expired expected=done");
    finishRun();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    check("R1 reset cfg", int'(cfgRdData), 13'h200);
    check("R1 reset counts", int'(txCount) + int'(rxCount), 0);
    check("R1 reset flags", int'({txThresh, rxThresh, txDmaReq, rxDmaReq,
                                  txOvr, txUnd, rxOvr, rxUnd}), 0);
    rstN = 1; live = 1;
    tick();
    check("R3 level zero requests", int'(rxDmaReq), 1);
    check("R4 dma disabled", int'(txDmaReq), 0);

    cfg(4, 8, 1, 1, 0); tick();
    for (int i = 0; i < DEPTH; i++) begin busTxPush = 1; busTxData = 8'(i * 7 + 3); tick(); end
    check("R2 tx full", int'(txCount), 32);
    busTxPush = 1; busTxData = 8'hEE; tick();
    check("R7 push to full", int'(txOvr), 1);
    // R10: set event and clear in the same cycle, set wins
    busTxPush = 1; flagClrEn = 1; flagClrMask = 4'b0001; tick();
    check("R10 set beats clear", int'(txOvr), 1);
    flagClrEn = 1; flagClrMask = 4'b0001; tick();
    check("R10 clear", int'(txOvr), 0);
    busTxPush = 1; shTxPop = 1; tick();
    check("R7 push+pop at full", int'(txOvr) * 100 + int'(txCount), 131);
    flagClrEn = 1; flagClrMask = 4'b0001; tick();
    for (int i = 0; i < 31; i++) begin shTxPop = 1; tick(); end
    shTxPop = 1; tick();
    check("R8 slave tx underrun", int'(txUnd), 1);
    slaveMode = 0; flagClrEn = 1; flagClrMask = 4'b0010; tick();
    shTxPop = 1; tick();
    check("R9 master no underrun", int'(txUnd), 0);
    check("R9 stall on empty", int'(sclkStall), 1);

    cfg(4, 8, 1, 0, 0); tick();
    busTxPush = 1; busTxData = 8'h55; tick();
    check("R5 disabled push ignored", int'(txCount) * 10 + int'(txOvr), 0);

    slaveMode = 1; cfg(4, 8, 1, 1, 0); tick();
    shTxPop = 1; tick();
    for (int i = 0; i < 5; i++) begin busTxPush = 1; busTxData = 8'(i); tick(); end
    cfg(4, 8, 1, 1, 1); busTxPush = 1; tick();
    check("R6 clear empties", int'(txCount), 0);
    check("R6 clear flags", int'({txUnd, txThresh, txDmaReq}), 0);
    tick();
    check("R6 thresh back", int'(txThresh), 1);
    busTxPush = 1; tick(); busTxPush = 1; tick();
    cfg(4, 8, 1, 1, 0); tick();
    check("R6 zero write no effect", int'(txCount) * 10 + int'(cfgRdData[12]), 20);

    for (int i = 0; i < DEPTH; i++) begin shRxPush = 1; shRxData = 8'(255 - i); tick(); end
    check("R3 rx above level", int'(rxThresh), 1);
    shRxPush = 1; tick();
    check("R8 slave rx overrun", int'(rxOvr), 1);
    slaveMode = 0; flagClrEn = 1; flagClrMask = 4'b0100; tick();
    shRxPush = 1; tick();
    check("R9 master no overrun", int'(rxOvr), 0);
    check("R9 stall on full", int'(sclkStall), 1);
    for (int i = 0; i < DEPTH; i++) begin busRxPop = 1; tick(); end
    busRxPop = 1; tick();
    check("R7 bus rx underrun", int'(rxUnd), 1);
    flagClrEn = 1; flagClrMask = 4'b1000; tick();
    check("R10 rx underrun cleared", int'(rxUnd), 0);
    cfg(4, 8, 0, 1, 0); tick(); tick();
    check("R4 disable drops req", int'(txDmaReq), 0);

    for (int n = 0; n < 1500; n++) begin
      if ($urandom_range(0, 19) == 0) begin
        cfgWrEn = 1;
        cfgWrData = {($urandom_range(0, 3) == 0), 1'($urandom),
                     1'($urandom), 5'($urandom), 5'($urandom_range(0, 30))};
      end
      if ($urandom_range(0, 7) == 0) begin flagClrEn = 1; flagClrMask = 4'($urandom); end
      if ($urandom_range(0, 29) == 0) slaveMode = ~slaveMode;
      busTxPush = 1'($urandom); busTxData = 8'($urandom);
      shTxPop   = ($urandom_range(0, 2) == 0);
      shRxPush  = 1'($urandom); shRxData = 8'($urandom);
      busRxPop  = ($urandom_range(0, 2) == 0);
      tick();
    end
    @(negedge clk);
    #1;
    finishRun();
  end
endmodule